// File: doc/BRIEF.md
# SHA-2 Vector Message Schedule Unit

This block runs the message-schedule expansion step of a vector SHA-2 instruction. Each element group holds four consecutive elements. For every group it produces four new schedule words from three operand arrays: the destination array (read and then overwritten) and two source arrays. The elements are either 32 bits wide (SHA-256) or 64 bits wide (SHA-512). The third and fourth words of a group depend on the first and second words computed in the same step. All four words are written back together.

An operation is started with a one-cycle `start` pulse. The instruction word, element width code, register-group multiplier code, tail policy, vector length and start index are sampled in that cycle. The block then drives a group index `op_grp`. The surrounding logic returns the three operand groups for that index combinationally, and the block writes the new group back through the same index. The block walks from group `vstart/4` up to, but not including, group `vl/4`, one group per clock. If tail-agnostic is selected, it then fills the remaining groups of the register group with ones. A one-cycle `done` pulse closes the operation. `err` flags an illegal request and `vstart_clr` tells the caller to clear its start index.

Top module: `sha2_ms_unit`

## Requirements
- R1: With `sew`=2 (32-bit elements), s0(x)=ror7^ror18^(x>>3) and s1(x)=ror17^ror19^(x>>10) on the low 32 bits. Each written element k sits at `wr_data[64k+63:64k]` and has its upper 32 bits zero. The upper 32 bits of the operand elements have no effect on the result.
- R2: With `sew`=3 (64-bit elements), s0(x)=ror1^ror8^(x>>7) and s1(x)=ror19^ror61^(x>>6) on the full 64 bits.
- R3: The words are w0=s1(B[2])+C[1]+s0(D[1])+D[0], w1=s1(B[3])+C[2]+s0(D[2])+D[1], w2=s1(w0)+C[3]+s0(D[3])+D[2] and w3=s1(w1)+B[0]+s0(C[0])+D[3]. D, B and C are the destination, first-source and second-source groups. All additions wrap at the element width, and all four words are written in the same cycle.
- R4: A legal run writes groups `vstart/4` through `vl/4-1` in ascending order, one per cycle. The first write appears in the cycle after the `start` edge.
- R5: If the request is legal and `vstart >= vl`, nothing is written. `done` pulses alone, without `err` or `vstart_clr`.
- R6: If `vl` or `vstart` is not a multiple of 4, the request is illegal. An illegal request gives `done` and `err` together for one cycle, one cycle after `start`, with no write and no `vstart_clr`.
- R7: The request is illegal if `sew` is neither 2 nor 3, if `sew`=3 while `allow64` is 0, or if `lmul[2]` is set. `lmul` codes 0 to 3 mean multipliers 1, 2, 4 and 8.
- R8: The request is illegal if the destination range [vd, vd+mult) overlaps either source range. vd is `insn[11:7]`, the first source is `insn[19:15]` and the second source is `insn[24:20]`.
- R9: The request is illegal if the register-group size `VLENB`<<lmul bytes is smaller than four elements (16 bytes for 32-bit elements, 32 bytes for 64-bit elements).
- R10: The request is illegal unless `insn[31:26]`=101101, `insn[25]`=1, `insn[14:12]`=010 and `insn[6:0]`=1110111.
- R11: With `tail_agn`=1, after the last computed group, groups `vl/4` up to (`VLENB`<<lmul)/(4·element bytes)−1 are written with every element all ones at the element width. With `tail_agn`=0, no group at or after `vl/4` is written.
- R12: After reset, `done`, `err`, `wr_en` and `vstart_clr` are low. For a legal run, `done` and `vstart_clr` pulse together for one cycle in the cycle after the last write.
- R13: A `start` pulse that arrives while an operation is running is ignored and does not change its writes or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| insn | input | 32 | Instruction word |
| sew | input | 2 | Element width code: 2 = 32-bit, 3 = 64-bit |
| allow64 | input | 1 | 64-bit element variant enabled |
| lmul | input | 3 | Register-group multiplier code |
| tail_agn | input | 1 | Tail-agnostic policy: fill the tail with ones |
| vl | input | VL_W | Vector length in elements |
| vstart | input | VL_W | Start element index |
| op_grp | output | GRP_W | Group index for operand read and write-back |
| vd_rdata | input | 256 | Destination group read data, element k at bits 64k+63:64k |
| vs1_rdata | input | 256 | First source group read data |
| vs2_rdata | input | 256 | Second source group read data |
| wr_en | output | 1 | Write `wr_data` to the destination group `op_grp` |
| wr_data | output | 256 | New destination group |
| done | output | 1 | Operation complete (one cycle) |
| err | output | 1 | Illegal request (with `done`) |
| vstart_clr | output | 1 | Clear the start index (with `done` on a legal run) |

## Verification
The bench builds the unit with `VLENB`=16. At that size a multiplier of 1 with 64-bit elements is too small and reaches the size rule. A multiplier of 8 gives at most eight groups, so both computed runs and tail fills cover several consecutive groups in short runs. With register numbers 0, 8 and 16, every multiplier stays free of overlap, so the overlap cases come only from deliberately placed registers. The bench model holds its own operand memories and expected write sequence. It checks the writes, the pulses and the group order cycle by cycle, including a stray `start` in the middle of a run.

// File: rtl/sha2_ms_pkg.sv
package sha2_ms_pkg;

    localparam int ELEM_W    = 64;
    localparam int GRP_ELEMS = 4;
    localparam int GRP_BITS  = ELEM_W * GRP_ELEMS;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    function automatic logic [63:0] rot64(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [31:0] rot32(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // keep only the active element width
    function automatic logic [63:0] fit(input logic [63:0] x, input logic wide);
        return wide ? x : {32'd0, x[31:0]};
    endfunction

    function automatic logic [63:0] sig_lo(input logic [63:0] x, input logic wide);
        if (wide) return rot64(x, 1) ^ rot64(x, 8) ^ (x >> 7);
        return {32'd0, rot32(x[31:0], 7) ^ rot32(x[31:0], 18) ^ (x[31:0] >> 3)};
    endfunction

    function automatic logic [63:0] sig_hi(input logic [63:0] x, input logic wide);
        if (wide) return rot64(x, 19) ^ rot64(x, 61) ^ (x >> 6);
        return {32'd0, rot32(x[31:0], 17) ^ rot32(x[31:0], 19) ^ (x[31:0] >> 10)};
    endfunction

endpackage

// File: rtl/sha2_ms_legal.sv
module sha2_ms_legal #(
    parameter int VLENB = 16,
    parameter int VL_W  = 6,
    parameter int GRP_W = 4
) (
    input  logic [31:0]      insn,
    input  logic [1:0]       sew,
    input  logic             allow64,
    input  logic [2:0]       lmul,
    input  logic [VL_W-1:0]  vl,
    input  logic [VL_W-1:0]  vstart,
    output logic             illegal,
    output logic             wide,
    output logic [GRP_W-1:0] tot_grp
);
    localparam int BYTES_W = $clog2(VLENB * 8 + 1);

    logic             enc_ok, sew_ok, mul_ok, size_ok, align_ok, ovl;
    logic [6:0]       span, rd_lo, s1_lo, s2_lo;
    logic [BYTES_W-1:0] grp_bytes;

    always_comb begin
        wide      = (sew == 2'd3);
        enc_ok    = (insn[31:26] == 6'b101101) && insn[25]
                 && (insn[14:12] == 3'b010) && (insn[6:0] == 7'b1110111);
        sew_ok    = (sew == 2'd2) || (wide && allow64);
        mul_ok    = !lmul[2];
        align_ok  = (vl[1:0] == 2'd0) && (vstart[1:0] == 2'd0);

        span      = 7'd1 << lmul[1:0];
        rd_lo     = {2'b00, insn[11:7]};
        s1_lo     = {2'b00, insn[19:15]};
        s2_lo     = {2'b00, insn[24:20]};
        ovl       = ((rd_lo < s1_lo + span) && (s1_lo < rd_lo + span))
                 || ((rd_lo < s2_lo + span) && (s2_lo < rd_lo + span));

        grp_bytes = BYTES_W'(VLENB) << lmul[1:0];
        size_ok   = wide ? (grp_bytes >= BYTES_W'(32)) : (grp_bytes >= BYTES_W'(16));
        tot_grp   = GRP_W'(wide ? (grp_bytes >> 5) : (grp_bytes >> 4));

        illegal   = !(enc_ok && sew_ok && mul_ok && align_ok && size_ok && !ovl);
    end

endmodule

// File: rtl/sha2_ms_word4.sv
module sha2_ms_word4
    import sha2_ms_pkg::*;
(
    input  logic                wide,
    input  logic [GRP_BITS-1:0] dst_in,
    input  logic [GRP_BITS-1:0] src1_in,
    input  logic [GRP_BITS-1:0] src2_in,
    output logic [GRP_BITS-1:0] word_out
);
    logic [ELEM_W-1:0] d [GRP_ELEMS];
    logic [ELEM_W-1:0] a [GRP_ELEMS];
    logic [ELEM_W-1:0] b [GRP_ELEMS];
    logic [ELEM_W-1:0] w [GRP_ELEMS];

    for (genvar k = 0; k < GRP_ELEMS; k++) begin : g_lane
        assign d[k] = dst_in[k*ELEM_W +: ELEM_W];
        assign a[k] = src1_in[k*ELEM_W +: ELEM_W];
        assign b[k] = src2_in[k*ELEM_W +: ELEM_W];
        assign word_out[k*ELEM_W +: ELEM_W] = w[k];
    end

    // words 2 and 3 chain on words 0 and 1 of this same group
    always_comb begin
        w[0] = fit(sig_hi(a[2], wide) + b[1] + sig_lo(d[1], wide) + d[0], wide);
        w[1] = fit(sig_hi(a[3], wide) + b[2] + sig_lo(d[2], wide) + d[1], wide);
        w[2] = fit(sig_hi(w[0], wide) + b[3] + sig_lo(d[3], wide) + d[2], wide);
        w[3] = fit(sig_hi(w[1], wide) + a[0] + sig_lo(b[0], wide) + d[3], wide);
    end

endmodule

// File: rtl/sha2_ms_unit.sv
module sha2_ms_unit
    import sha2_ms_pkg::*;
#(
    parameter int VLENB     = 16,
    localparam int MAX_ELEMS = VLENB * 2,
    localparam int VL_W      = $clog2(MAX_ELEMS + 1),
    localparam int GRP_W     = $clog2(MAX_ELEMS / 4 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         insn,
    input  logic [1:0]          sew,
    input  logic                allow64,
    input  logic [2:0]          lmul,
    input  logic                tail_agn,
    input  logic [VL_W-1:0]     vl,
    input  logic [VL_W-1:0]     vstart,
    output logic [GRP_W-1:0]    op_grp,
    input  logic [GRP_BITS-1:0] vd_rdata,
    input  logic [GRP_BITS-1:0] vs1_rdata,
    input  logic [GRP_BITS-1:0] vs2_rdata,
    output logic                wr_en,
    output logic [GRP_BITS-1:0] wr_data,
    output logic                done,
    output logic                err,
    output logic                vstart_clr
);
    typedef struct packed {
        phase_e           ph;
        logic             wide;
        logic             tail;
        logic [GRP_W-1:0] grp;
        logic [GRP_W-1:0] stop;
        logic [GRP_W-1:0] tot;
        logic             done;
        logic             err;
        logic             vclr;
    } st_t;

    st_t st_d, st_q;

    logic             req_bad, req_wide;
    logic [GRP_W-1:0] req_tot;
    logic             cur_wide;
    logic [GRP_BITS-1:0] calc_grp, ones_grp;

    sha2_ms_legal #(.VLENB(VLENB), .VL_W(VL_W), .GRP_W(GRP_W)) u_legal (
        .insn    (insn),
        .sew     (sew),
        .allow64 (allow64),
        .lmul    (lmul),
        .vl      (vl),
        .vstart  (vstart),
        .illegal (req_bad),
        .wide    (req_wide),
        .tot_grp (req_tot)
    );

    assign cur_wide = st_q.wide;

    sha2_ms_word4 u_word (
        .wide     (cur_wide),
        .dst_in   (vd_rdata),
        .src1_in  (vs1_rdata),
        .src2_in  (vs2_rdata),
        .word_out (calc_grp)
    );

    assign ones_grp = {GRP_ELEMS{cur_wide ? {ELEM_W{1'b1}} : {32'd0, 32'hFFFF_FFFF}}};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        st_d.vclr = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (req_bad) begin
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else if (vstart >= vl) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.ph   = PH_RUN;
                        st_d.wide = req_wide;
                        st_d.tail = tail_agn;
                        st_d.grp  = GRP_W'(vstart >> 2);
                        st_d.stop = GRP_W'(vl >> 2);
                        st_d.tot  = req_tot;
                    end
                end
            end
            PH_RUN: begin
                st_d.grp = st_q.grp + GRP_W'(1);
                if (st_d.grp == st_q.stop) begin
                    if (st_q.tail && (st_q.stop < st_q.tot)) begin
                        st_d.ph = PH_TAIL;
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                        st_d.vclr = 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                st_d.grp = st_q.grp + GRP_W'(1);
                if (st_d.grp == st_q.tot) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                    st_d.vclr = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op_grp     = st_q.grp;
    assign wr_en      = (st_q.ph == PH_RUN) || (st_q.ph == PH_TAIL);
    assign wr_data    = (st_q.ph == PH_TAIL) ? ones_grp : calc_grp;
    assign done       = st_q.done;
    assign err        = st_q.err;
    assign vstart_clr = st_q.vclr;

endmodule

// File: rtl/sha2_ms_unit_chk.sv
module sha2_ms_unit_chk #(
    parameter int GRP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [GRP_W-1:0] op_grp,
    input logic             wr_en,
    input logic [255:0]     wr_data,
    input logic             done,
    input logic             err,
    input logic             vstart_clr,
    input logic             cur_wide
);
    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R6
    err_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(start));

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R12
    clear_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vstart_clr |-> (done && !err));

    // R4
    grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (op_grp == $past(op_grp) + GRP_W'(1)));

    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cur_wide) |-> ((wr_data[63:32] == 32'd0) && (wr_data[127:96] == 32'd0)
                                && (wr_data[191:160] == 32'd0) && (wr_data[255:224] == 32'd0)));

endmodule

bind sha2_ms_unit sha2_ms_unit_chk #(.GRP_W(GRP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_grp     (op_grp),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .done       (done),
    .err        (err),
    .vstart_clr (vstart_clr),
    .cur_wide   (cur_wide)
);

// File: tb/sim_sha2_ms_unit.sv
`timescale 1ns/1ps
module sim_sha2_ms_unit;
    localparam int VLENB = 16;
    localparam int VL_W  = $clog2(VLENB * 2 + 1);
    localparam int GRP_W = $clog2(VLENB / 2 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0] sew = '0;
    logic allow64 = 1'b0;
    logic [2:0] lmul = '0;
    logic tail_agn = 1'b0;
    logic [VL_W-1:0] vl = '0, vstart = '0;
    logic [GRP_W-1:0] op_grp;
    logic [255:0] vd_rdata, vs1_rdata, vs2_rdata, wr_data;
    logic wr_en, done, err, vstart_clr;

    always #2.5 clk = ~clk;

    sha2_ms_unit #(.VLENB(VLENB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .sew(sew),
        .allow64(allow64), .lmul(lmul), .tail_agn(tail_agn), .vl(vl), .vstart(vstart),
        .op_grp(op_grp), .vd_rdata(vd_rdata), .vs1_rdata(vs1_rdata), .vs2_rdata(vs2_rdata),
        .wr_en(wr_en), .wr_data(wr_data), .done(done), .err(err), .vstart_clr(vstart_clr)
    );

    logic [63:0] m_vd [0:31];
    logic [63:0] m_s1 [0:31];
    logic [63:0] m_s2 [0:31];

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            vd_rdata[64*k +: 64]  = m_vd[(int'(op_grp) * 4 + k) % 32];
            vs1_rdata[64*k +: 64] = m_s1[(int'(op_grp) * 4 + k) % 32];
            vs2_rdata[64*k +: 64] = m_s2[(int'(op_grp) * 4 + k) % 32];
        end
    end

    always @(posedge clk) begin
        if (wr_en)
            for (int k = 0; k < 4; k++)
                m_vd[(int'(op_grp) * 4 + k) % 32] <= wr_data[64*k +: 64];
    end

    typedef struct {
        bit          we;
        int          grp;
        logic [255:0] data;
        bit          dn;
        bit          er;
        bit          vc;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit fin = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !fin) begin
            total++; bad++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [63:0] rr(input logic [63:0] x, input int n, input bit w);
        logic [31:0] y;
        if (w) return (x >> n) | (x << (64 - n));
        y = x[31:0];
        return {32'd0, (y >> n) | (y << (32 - n))};
    endfunction

    function automatic logic [63:0] f_s0(input logic [63:0] x, input bit w);
        if (w) return rr(x, 1, 1) ^ rr(x, 8, 1) ^ (x >> 7);
        return rr(x, 7, 0) ^ rr(x, 18, 0) ^ {32'd0, x[31:0] >> 3};
    endfunction

    function automatic logic [63:0] f_s1(input logic [63:0] x, input bit w);
        if (w) return rr(x, 19, 1) ^ rr(x, 61, 1) ^ (x >> 6);
        return rr(x, 17, 0) ^ rr(x, 19, 0) ^ {32'd0, x[31:0] >> 10};
    endfunction

    function automatic logic [63:0] cut(input logic [63:0] x, input bit w);
        return w ? x : {32'd0, x[31:0]};
    endfunction

    function automatic logic [63:0] mix(input int i, input int salt);
        logic [63:0] x;
        x = 64'(i + salt * 37 + 1) * 64'h9E3779B97F4A7C15;
        x = x ^ (x >> 29);
        return x * 64'hBF58476D1CE4E5B9;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm, input int s2,
                                       input int s1, input logic [2:0] f3, input int d,
                                       input logic [6:0] op);
        return {f6, vm, 5'(s2), 5'(s1), f3, 5'(d), op};
    endfunction

    function automatic logic [31:0] gi(input int d, input int s1, input int s2);
        return mk(6'b101101, 1'b1, s2, s1, 3'b010, d, 7'b1110111);
    endfunction

    task automatic chk1(input string tag, input string what, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, expv);
        end
    endtask

    task automatic chk_item(input string tag, input item_t it);
        chk1(tag, "wr_en", wr_en, it.we);
        chk1(tag, "done", done, it.dn);
        chk1(tag, "err", err, it.er);
        chk1(tag, "vstart_clr", vstart_clr, it.vc);
        if (it.we && wr_en) begin
            total++;
            if (int'(op_grp) != it.grp) begin
                bad++;
                $display("FAIL %s group: actual=%0d expected=%0d", tag, op_grp, it.grp);
            end
            total++;
            if (wr_data !== it.data) begin
                bad++;
                $display("FAIL %s data: actual=%h expected=%h", tag, wr_data, it.data);
            end
        end
    endtask

    task automatic do_op(input string tag, input logic [31:0] ins, input logic [1:0] s,
                         input bit a64, input logic [2:0] lm, input bit ta, input int vlv,
                         input int vsv, input bit is_bad, input bit poke);
        item_t it, idle;
        bit w;
        int tot, n;
        logic [63:0] d[4], a[4], b[4], r[4];
        w = (s == 2'd3);
        q.delete();
        idle.we = 0; idle.grp = 0; idle.data = '0; idle.dn = 0; idle.er = 0; idle.vc = 0;
        @(negedge clk);
        insn = ins; sew = s; allow64 = a64; lmul = lm; tail_agn = ta;
        vl = VL_W'(vlv); vstart = VL_W'(vsv); start = 1'b1;
        it = idle;
        if (is_bad) begin
            it.dn = 1; it.er = 1; q.push_back(it);
        end else if (vsv >= vlv) begin
            it.dn = 1; q.push_back(it);
        end else begin
            for (int g = vsv / 4; g < vlv / 4; g++) begin
                for (int k = 0; k < 4; k++) begin
                    d[k] = m_vd[g*4+k]; a[k] = m_s1[g*4+k]; b[k] = m_s2[g*4+k];
                end
                r[0] = cut(f_s1(a[2], w) + b[1] + f_s0(d[1], w) + d[0], w);
                r[1] = cut(f_s1(a[3], w) + b[2] + f_s0(d[2], w) + d[1], w);
                r[2] = cut(f_s1(r[0], w) + b[3] + f_s0(d[3], w) + d[2], w);
                r[3] = cut(f_s1(r[1], w) + a[0] + f_s0(b[0], w) + d[3], w);
                it = idle; it.we = 1; it.grp = g; it.data = {r[3], r[2], r[1], r[0]};
                q.push_back(it);
            end
            tot = (VLENB << lm) / (w ? 32 : 16);
            if (ta)
                for (int g = vlv / 4; g < tot; g++) begin
                    it = idle; it.we = 1; it.grp = g;
                    it.data = {4{w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF}};
                    q.push_back(it);
                end
            it = idle; it.dn = 1; it.vc = 1; q.push_back(it);
        end
        n = q.size();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_item(tag, q[i]);
            start = (poke && i == 1);
            if (poke && i == 1) insn = 32'h0;
        end
        start = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk_item(tag, idle);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_vd[i] = mix(i, 1);
            m_s1[i] = mix(i, 2);
            m_s2[i] = mix(i, 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk1("R12 reset", "done", done, 1'b0);
        chk1("R12 reset", "err", err, 1'b0);
        chk1("R12 reset", "wr_en", wr_en, 1'b0);
        chk1("R12 reset", "vstart_clr", vstart_clr, 1'b0);

        // tag, insn, sew, allow64, lmul, tail, vl, vstart, illegal, poke
        do_op("R1 R3 narrow",       gi(0, 8, 16), 2'd2, 0, 3'd0, 0, 4,  0, 0, 0);
        do_op("R2 wide",            gi(0, 8, 16), 2'd3, 1, 3'd1, 0, 4,  0, 0, 0);
        do_op("R4 R11 narrow tail", gi(0, 8, 16), 2'd2, 0, 3'd2, 1, 12, 4, 0, 0);
        do_op("R11 undisturbed",    gi(0, 8, 16), 2'd2, 0, 3'd2, 0, 12, 4, 0, 0);
        do_op("R2 R11 wide tail",   gi(0, 8, 16), 2'd3, 1, 3'd3, 1, 8,  0, 0, 0);
        do_op("R5 empty",           gi(0, 8, 16), 2'd2, 0, 3'd1, 1, 8,  8, 0, 0);
        do_op("R6 vl misaligned",   gi(0, 8, 16), 2'd2, 0, 3'd1, 1, 6,  0, 1, 0);
        do_op("R6 vstart misaligned", gi(0, 8, 16), 2'd2, 0, 3'd1, 1, 8, 2, 1, 0);
        do_op("R7 bad sew",         gi(0, 8, 16), 2'd0, 1, 3'd1, 0, 4,  0, 1, 0);
        do_op("R7 wide disabled",   gi(0, 8, 16), 2'd3, 0, 3'd1, 0, 4,  0, 1, 0);
        do_op("R7 fractional",      gi(0, 8, 16), 2'd2, 0, 3'd5, 0, 4,  0, 1, 0);
        do_op("R8 overlap src1",    gi(0, 1, 16), 2'd2, 0, 3'd1, 0, 4,  0, 1, 0);
        do_op("R8 overlap src2",    gi(4, 16, 2), 2'd2, 0, 3'd2, 0, 4,  0, 1, 0);
        do_op("R9 group too small", gi(0, 8, 16), 2'd3, 1, 3'd0, 0, 4,  0, 1, 0);
        do_op("R10 wrong funct6",   mk(6'b101100, 1'b1, 16, 8, 3'b010, 0, 7'b1110111),
                                    2'd2, 0, 3'd0, 0, 4, 0, 1, 0);
        do_op("R10 masked form",    mk(6'b101101, 1'b0, 16, 8, 3'b010, 0, 7'b1110111),
                                    2'd2, 0, 3'd0, 0, 4, 0, 1, 0);
        do_op("R13 R12 busy start", gi(0, 8, 16), 2'd3, 1, 3'd3, 1, 16, 0, 0, 1);
        do_op("R1 R4 narrow long",  gi(0, 8, 16), 2'd2, 0, 3'd3, 0, 32, 8, 0, 0);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule